// File: doc/BRIEF.md
# OS Bank Controller

This block sits on a byte-wide 8-bit CPU bus and chooses what answers in the top 16 KB of the address space ($C000 to $FFFF). That region comes either from the stock OS ROM or from one of several 16 KB banks of a larger SRAM. A single write-only control register at $D180 makes the choice, write-enables the SRAM and picks the bank. An active-low joystick fire input, held at power-up, forces the ROM. This gives a way back when the SRAM holds an unusable image. Once software sets the override bit, the button no longer affects the mapping. The block also maps an extra 512-byte driver window at $D600 to $D7FF into SRAM, at the matching offset of the current bank. The rest of the I/O page $D000 to $D7FF never selects either memory.

All state changes on the falling edge of the bus clock `phi2`. The control register and a map state machine update on the same edge. The state machine has three states:
- `MAP_SRAM`: the OS region is served by SRAM. The machine enters this state on reset.
- `MAP_ROM_SOFT`: software has set the ROM-select bit.
- `MAP_ROM_FIRE`: the fire button forces the ROM while the override bit is clear.

The next state is computed from the control value that is valid after the edge and from the fire input sampled at that edge. The transitions are:
- `to_soft`: any state goes to `MAP_ROM_SOFT` when bit 6 is 1.
- `to_fire`: the machine goes to `MAP_ROM_FIRE` when bit 6 is 0, bit 7 is 0 and fire is low.
- `to_sram`: any state goes to `MAP_SRAM` otherwise.
- `latch_rom`: `MAP_ROM_FIRE` goes to `MAP_ROM_SOFT` when software writes bit 6. The ROM then stays selected after the button is released.

The chip selects are combinational in the address, so a new mapping applies from the bus cycle that follows the edge.

Top module: `osb_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, all eight control bits read as 0 and the map state is `MAP_SRAM`. An OS-region access then selects SRAM bank 0 with writes blocked.
- R2: A cycle with `cpu_rw_n`=0 and `cpu_addr` exactly $D180 loads `cpu_data` into the control register at the falling edge of `phi2`. The new value governs the next bus cycle. Reads at $D180 and writes to any other address leave the register unchanged.
- R3: With control bit 6 = 1, `rom_cs_n` is 0 and `sram_cs_n` is 1 for addresses $C000 to $CFFF and $D800 to $FFFF.
- R4: With bit 7 = 0 and bit 6 = 0, `fire_n` = 0 sampled at a falling edge of `phi2` selects the ROM for the following cycle. With bit 7 = 1, `fire_n` has no effect on any output.
- R5: `sram_we_n` is 0 only when all of the following hold: `phi2` is high, `cpu_rw_n` is 0, `sram_cs_n` is 0, and control bit 5 is 1. While `phi2` is low, `sram_we_n` is 1.
- R6: `sram_bank` equals the control bits [BANK_BITS-1:0], with bit 0 on the lowest upper address line (A14). With the default BANK_BITS = 3, bits 3 and 4 do not affect `sram_bank`.
- R7: For $D600 to $D7FF, `sram_cs_n` is 0 and `rom_cs_n` is 1 in every map state. This window is subject to the bit 5 write gating of R5.
- R8: For $D000 to $D5FF and for $0000 to $BFFF, both `rom_cs_n` and `sram_cs_n` are 1.
- R9: The ROM and SRAM chip selects are never low together. After `latch_rom` (bit 6 written as 1 while in `MAP_ROM_FIRE`), the ROM stays selected when `fire_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Bus phase-2 clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (written value) |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| fire_n | input | 1 | Joystick fire button, active low |
| rom_cs_n | output | 1 | OS ROM chip select, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write strobe, active low, qualified by phi2 high |
| sram_bank | output | BANK_BITS | SRAM upper address lines A14 upward |

## Verification
The assertions assume the following about the inputs: the address, data, read/write and fire inputs are stable around each falling edge of `phi2`, and reset is released away from that edge. The bench meets this by changing every input shortly after a falling edge. It then looks at the write strobe while `phi2` is still low and at all outputs in the middle of the high phase. Random cycles favour the register address, the OS window and the I/O page, and hold the fire level for several cycles at a time. Directed cases cover forcing by the button, masking it, latching into ROM and the write gating.

// File: rtl/osb_pkg.sv
package osb_pkg;

    localparam logic [15:0] CTL_ADDR = 16'hD180;

    typedef enum logic [1:0] {
        MAP_SRAM     = 2'd0,
        MAP_ROM_SOFT = 2'd1,
        MAP_ROM_FIRE = 2'd2
    } map_e;

    localparam int CTL_ROM_BIT = 6;
    localparam int CTL_OVR_BIT = 7;
    localparam int CTL_WEN_BIT = 5;

endpackage

// File: rtl/osb_ctrl_reg.sv
module osb_ctrl_reg #(
    parameter int          WIDTH    = 8,
    parameter logic [15:0] REG_ADDR = 16'hD180
) (
    input  logic             phi2,
    input  logic             rst_n,
    input  logic [15:0]      cpu_addr,
    input  logic [WIDTH-1:0] cpu_data,
    input  logic             cpu_rw_n,
    output logic [WIDTH-1:0] ctl_q,
    output logic [WIDTH-1:0] ctl_d
);

    logic hit_wr;

    // Exact full-address match on a write cycle only.
    always_comb begin
        hit_wr = !cpu_rw_n && (cpu_addr == REG_ADDR);
        ctl_d  = hit_wr ? cpu_data : ctl_q;
    end

    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/osb_map_fsm.sv
module osb_map_fsm
    import osb_pkg::*;
(
    input  logic phi2,
    input  logic rst_n,
    input  logic rom_bit_d,
    input  logic ovr_bit_d,
    input  logic fire_n,
    output map_e state,
    output logic rom_sel
);

    map_e state_nx;
    logic fire_live;

    always_comb begin
        fire_live = !fire_n && !ovr_bit_d;
        state_nx  = state;
        unique case (state)
            MAP_SRAM: begin
                if (rom_bit_d)      state_nx = MAP_ROM_SOFT;   // to_soft
                else if (fire_live) state_nx = MAP_ROM_FIRE;   // to_fire
                else                state_nx = MAP_SRAM;
            end
            MAP_ROM_SOFT: begin
                if (rom_bit_d)      state_nx = MAP_ROM_SOFT;
                else if (fire_live) state_nx = MAP_ROM_FIRE;   // to_fire
                else                state_nx = MAP_SRAM;       // to_sram
            end
            MAP_ROM_FIRE: begin
                if (rom_bit_d)      state_nx = MAP_ROM_SOFT;   // latch_rom
                else if (fire_live) state_nx = MAP_ROM_FIRE;
                else                state_nx = MAP_SRAM;       // to_sram
            end
            default:                state_nx = MAP_SRAM;
        endcase
    end

    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) begin
            state <= MAP_SRAM;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            MAP_ROM_SOFT: rom_sel = 1'b1;
            MAP_ROM_FIRE: rom_sel = 1'b1;
            default:      rom_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/osb_addr_decode.sv
module osb_addr_decode (
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw_n,
    input  logic        phi2,
    input  logic        rom_sel,
    input  logic        wr_en,
    output logic        rom_cs_n,
    output logic        sram_cs_n,
    output logic        sram_we_n
);

    logic in_top, in_io, in_drv, os_area, sram_hit;

    always_comb begin
        in_top   = (cpu_addr[15:14] == 2'b11);
        in_io    = (cpu_addr[15:11] == 5'b11010);
        in_drv   = (cpu_addr[15:9]  == 7'b1101011);
        os_area  = in_top && !in_io;
        sram_hit = (os_area && !rom_sel) || in_drv;
        rom_cs_n = !(os_area && rom_sel);
        sram_cs_n = !sram_hit;
        sram_we_n = !(sram_hit && !cpu_rw_n && wr_en && phi2);
    end

endmodule

// File: rtl/osb_bank_ctrl.sv
module osb_bank_ctrl
    import osb_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input  logic                 phi2,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_rw_n,
    input  logic                 fire_n,
    output logic                 rom_cs_n,
    output logic                 sram_cs_n,
    output logic                 sram_we_n,
    output logic [BANK_BITS-1:0] sram_bank
);

    localparam int CTL_W = 8;

    logic [CTL_W-1:0] ctl_q;
    logic [CTL_W-1:0] ctl_d;
    map_e             map_state;
    logic             rom_sel;

    osb_ctrl_reg #(.WIDTH(CTL_W), .REG_ADDR(CTL_ADDR)) u_reg (
        .phi2     (phi2),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_rw_n (cpu_rw_n),
        .ctl_q    (ctl_q),
        .ctl_d    (ctl_d)
    );

    osb_map_fsm u_fsm (
        .phi2      (phi2),
        .rst_n     (rst_n),
        .rom_bit_d (ctl_d[CTL_ROM_BIT]),
        .ovr_bit_d (ctl_d[CTL_OVR_BIT]),
        .fire_n    (fire_n),
        .state     (map_state),
        .rom_sel   (rom_sel)
    );

    osb_addr_decode u_dec (
        .cpu_addr  (cpu_addr),
        .cpu_rw_n  (cpu_rw_n),
        .phi2      (phi2),
        .rom_sel   (rom_sel),
        .wr_en     (ctl_q[CTL_WEN_BIT]),
        .rom_cs_n  (rom_cs_n),
        .sram_cs_n (sram_cs_n),
        .sram_we_n (sram_we_n)
    );

    assign sram_bank = ctl_q[BANK_BITS-1:0];

endmodule

// File: rtl/osb_bank_ctrl_chk.sv
module osb_bank_ctrl_chk
    import osb_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input logic                 phi2,
    input logic                 rst_n,
    input logic [15:0]          cpu_addr,
    input logic [7:0]           cpu_data,
    input logic                 cpu_rw_n,
    input logic                 fire_n,
    input logic                 rom_cs_n,
    input logic                 sram_cs_n,
    input logic                 sram_we_n,
    input logic [BANK_BITS-1:0] sram_bank,
    input logic [7:0]           ctl_q,
    input map_e                 map_state
);

    // R1
    always @(negedge phi2) begin
        if (!rst_n) begin
            reset_clear_chk: assert (ctl_q == 8'h00 && map_state == MAP_SRAM);
        end
    end

    // R2
    reg_load_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        (!cpu_rw_n && cpu_addr == CTL_ADDR) |=> (ctl_q == $past(cpu_data)));

    // R2
    reg_hold_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        !(!cpu_rw_n && cpu_addr == CTL_ADDR) |=> $stable(ctl_q));

    // R3
    soft_rom_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        ctl_q[CTL_ROM_BIT] |-> (map_state == MAP_ROM_SOFT));

    // R4
    override_mask_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        (ctl_q[CTL_OVR_BIT] && !ctl_q[CTL_ROM_BIT]) |-> (map_state == MAP_SRAM));

    // R5
    we_gate_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs_n && !cpu_rw_n && ctl_q[CTL_WEN_BIT]));

    // R8
    io_quiet_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        (cpu_addr[15:11] == 5'b11010 && cpu_addr[10:9] != 2'b11) |-> (rom_cs_n && sram_cs_n));

    // R9
    cs_excl_chk: assert property (@(negedge phi2) disable iff (!rst_n)
        !(!rom_cs_n && !sram_cs_n));

endmodule

bind osb_bank_ctrl osb_bank_ctrl_chk #(.BANK_BITS(BANK_BITS)) u_chk (.*);

// File: tb/sim_osb_bank_ctrl.sv
module sim_osb_bank_ctrl;

    localparam int PERIOD = 100;
    localparam int HALF   = PERIOD / 2;
    localparam int BB     = 3;

    logic          phi2 = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = 16'h0000;
    logic [7:0]    cpu_data = 8'h00;
    logic          cpu_rw_n = 1'b1;
    logic          fire_n = 1'b1;
    logic          rom_cs_n, sram_cs_n, sram_we_n;
    logic [BB-1:0] sram_bank;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_ctl = 8'h00;
    logic       m_rom = 1'b0;
    int unsigned dummy;

    osb_bank_ctrl #(.BANK_BITS(BB)) u0 (.*);

    always #(HALF) phi2 = ~phi2;

    function automatic logic os_area(input logic [15:0] a);
        return (a >= 16'hC000) && !(a >= 16'hD000 && a <= 16'hD7FF);
    endfunction

    function automatic logic drv_area(input logic [15:0] a);
        return (a >= 16'hD600 && a <= 16'hD7FF);
    endfunction

    function automatic logic exp_rom_n(input logic [15:0] a, input logic rom);
        return !(os_area(a) && rom);
    endfunction

    function automatic logic exp_sram_n(input logic [15:0] a, input logic rom);
        return !((os_area(a) && !rom) || drv_area(a));
    endfunction

    function automatic logic exp_we_n(input logic [15:0] a, input logic rom,
                                      input logic rw, input logic [7:0] c);
        return !(!exp_sram_n(a, rom) && !rw && c[5]);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: entered just after a falling edge, leaves just after the next.
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw,
                       input logic f, input string tag);
        cpu_addr = a; cpu_data = d; cpu_rw_n = rw; fire_n = f;
        #5;
        chk("R5", "we_n phi2 low", int'(sram_we_n), 1);
        @(posedge phi2);
        #10;
        chk(tag, "rom_cs_n", int'(rom_cs_n), int'(exp_rom_n(a, m_rom)));
        chk(tag, "sram_cs_n", int'(sram_cs_n), int'(exp_sram_n(a, m_rom)));
        chk(tag, "sram_we_n", int'(sram_we_n), int'(exp_we_n(a, m_rom, rw, m_ctl)));
        chk(tag, "sram_bank", int'(sram_bank), int'(m_ctl[BB-1:0]));
        @(negedge phi2);
        if (!rw && a == 16'hD180) m_ctl = d;
        m_rom = m_ctl[6] || (!m_ctl[7] && !f);
        #1;
    endtask

    task automatic do_reset(input logic f);
        @(negedge phi2); #1;
        rst_n = 1'b0; fire_n = f; cpu_addr = 16'hC000; cpu_rw_n = 1'b0; cpu_data = 8'hFF;
        @(posedge phi2); #10;
        // R1: cleared register, SRAM bank 0, no write strobe
        chk("R1", "rom_cs_n", int'(rom_cs_n), 1);
        chk("R1", "sram_cs_n", int'(sram_cs_n), 0);
        chk("R1", "sram_we_n", int'(sram_we_n), 1);
        chk("R1", "sram_bank", int'(sram_bank), 0);
        @(negedge phi2); #20;
        rst_n = 1'b1;
        m_ctl = 8'h00; m_rom = 1'b0;
        @(negedge phi2); #1;
        cpu_rw_n = 1'b1;
        m_rom = !f;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        dummy = $urandom(32'h0C0FFEE5);
        do_reset(1'b1);

        // R2: load ROM select, applies next cycle
        bus(16'hD180, 8'h40, 1'b0, 1'b1, "R2");
        bus(16'hC000, 8'h00, 1'b1, 1'b1, "R3");
        bus(16'hFFFC, 8'h00, 1'b1, 1'b1, "R3");
        // R7: driver window stays on SRAM with ROM chosen
        bus(16'hD600, 8'h00, 1'b1, 1'b1, "R7");
        bus(16'hD7FF, 8'h00, 1'b1, 1'b1, "R7");
        // R8: I/O page and low memory select nothing
        bus(16'hD000, 8'h00, 1'b1, 1'b1, "R8");
        bus(16'hD5FF, 8'h00, 1'b1, 1'b1, "R8");
        bus(16'hBFFF, 8'h00, 1'b1, 1'b1, "R8");
        // back to SRAM; fire forces ROM
        bus(16'hD180, 8'h00, 1'b0, 1'b1, "R2");
        bus(16'hE000, 8'h00, 1'b1, 1'b0, "R4");
        bus(16'hE000, 8'h00, 1'b1, 1'b0, "R4");
        // R9: latch_rom then release button
        bus(16'hD180, 8'h40, 1'b0, 1'b0, "R9");
        bus(16'hE000, 8'h00, 1'b1, 1'b1, "R9");
        bus(16'hE000, 8'h00, 1'b1, 1'b1, "R9");
        // R4: override masks the button
        bus(16'hD180, 8'h80, 1'b0, 1'b0, "R4");
        bus(16'hE000, 8'h00, 1'b1, 1'b0, "R4");
        bus(16'hE000, 8'h00, 1'b1, 1'b0, "R4");
        // R5: writes blocked then enabled, bank 5
        bus(16'hE000, 8'h11, 1'b0, 1'b1, "R5");
        bus(16'hD180, 8'hA5, 1'b0, 1'b1, "R2");
        bus(16'hE000, 8'h11, 1'b0, 1'b1, "R5");
        bus(16'hD700, 8'h22, 1'b0, 1'b1, "R7");
        // R2: read at register and near-miss write are ignored
        bus(16'hD180, 8'h00, 1'b1, 1'b1, "R2");
        bus(16'hD181, 8'h00, 1'b0, 1'b1, "R2");
        bus(16'hC123, 8'h00, 1'b1, 1'b1, "R2");
        // R6: spare bits 3 and 4 do not reach the bank lines
        bus(16'hD180, 8'h9B, 1'b0, 1'b1, "R6");
        bus(16'hC000, 8'h00, 1'b1, 1'b1, "R6");
        // R1: reset with button held starts in SRAM, then ROM
        do_reset(1'b0);
        bus(16'hC000, 8'h00, 1'b1, 1'b0, "R4");

        begin
            logic f = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                logic [15:0] a;
                logic [7:0]  d;
                logic        rw;
                int unsigned pick = $urandom % 8;
                if ($urandom % 24 == 0) f = ~f;
                d  = 8'($urandom);
                rw = 1'($urandom);
                unique case (pick)
                    0, 1:    a = 16'hD180;
                    2, 3:    a = 16'hC000 | 16'($urandom % 16'h4000);
                    4:       a = 16'hD000 | 16'($urandom % 16'h0800);
                    5:       a = 16'hD600 | 16'($urandom % 16'h0200);
                    default: a = 16'($urandom);
                endcase
                bus(a, d, rw, f, "R3");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule